// File: doc/BRIEF.md
# I2C Master Byte Staging Buffer

This block holds up to four bytes between a processor register port and an I2C master transfer engine. The processor adds bytes by writing the buffer register and removes them by reading it. The transfer engine loads received bytes into the buffer and takes outgoing bytes from it. Bytes leave in the order they arrived, and the oldest byte is always visible on `head_data`.

Outside the block, the occupancy is a signed fill index: -1 means empty and 3 means full. Two registered flags, "full" and "has data", feed the neighbouring status register, where they appear as bits 4 and 5. A write to the mode control register with bit 6 set flushes the buffer. The engine, the processor and the flush control all use a plain strobe interface. When the engine and the processor act in the same cycle, the engine goes first and the processor is told to retry.

Top module: `xfer_byte_stage`

## Requirements
- R1: After reset, `fill_idx` is -1, `buf_full` and `buf_has_data` are 0, and `head_data` reads 0xFF.
- R2: An accepted processor write puts `cpu_wdata` behind the bytes already held and raises `fill_idx` by one in the next cycle. A write while `fill_idx` is 3 is ignored and leaves the contents and the index unchanged.
- R3: A write that takes `fill_idx` from -1 to 0 sets `buf_has_data`. A write that takes it from 2 to 3 sets `buf_full`. These flags are the status bits 5 and 4.
- R4: `head_data` shows the oldest byte before the pop. An accepted processor read removes that byte, the remaining bytes move one place toward the head, and `fill_idx` drops by one in the next cycle.
- R5: A read while empty returns 0xFF on `head_data` and changes neither the index nor the flags.
- R6: A read taken at index 3 clears `buf_full`. A read taken at index 0 clears `buf_has_data`.
- R7: A `ctl_wr_en` write with `ctl_wdata` bit 6 set empties the buffer: `fill_idx` becomes -1, both flags clear and every entry is zeroed. A control write with bit 6 clear has no effect.
- R8: An engine load (`eng_push`) follows the same rules as a processor write, and an engine take (`eng_pop`) follows the same rules as a processor read. If both strobes are high together, only the load is taken.
- R9: If `eng_push` or `eng_pop` is high in the same cycle as a processor access, `cpu_stall` is high and the processor access is not performed. A processor write has precedence over a simultaneous processor read.
- R10: A flush has precedence over every other access in its cycle. `cpu_stall` is high if a processor access coincides with it.
- R11: The index and the flags are registered and change only in the cycle after the access that moves them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Processor write to the buffer register |
| cpu_rd_en | input | 1 | Processor read of the buffer register (pop) |
| cpu_wdata | input | 8 | Processor write byte |
| ctl_wr_en | input | 1 | Write strobe of the mode control register |
| ctl_wdata | input | 8 | Mode control write data; bit 6 flushes |
| eng_push | input | 1 | Engine loads a received byte |
| eng_pop | input | 1 | Engine takes the head byte to send |
| eng_wdata | input | 8 | Byte loaded by the engine |
| head_data | output | 8 | Oldest byte, or 0xFF when empty |
| cpu_stall | output | 1 | Processor access not taken this cycle |
| fill_idx | output | 3 | Signed fill index, -1 empty to 3 full |
| buf_full | output | 1 | Full flag (status bit 4) |
| buf_has_data | output | 1 | Has-data flag (status bit 5) |

## Verification
The buffer is filled with distinct byte values and then overrun with a fifth byte. Reading the bytes back in order exposes loss, reordering or an overwrite caused by the ignored write, and the 0xFF after the last byte shows the true empty point. The flags are sampled after every single step, so an update at the wrong transition shows up as a flag set or cleared one step early or late. Mixed sequences with engine loads and takes, coincident engine and processor strobes, and flushes with and without bit 6 separate the priority order of flush, engine and processor.

// File: rtl/xfer_stage_pkg.sv
package xfer_stage_pkg;

    localparam int FLUSH_BIT = 6;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_FLUSH = 2'd3
    } stage_op_e;

endpackage

// File: rtl/xfer_stage_arb.sv
module xfer_stage_arb
    import xfer_stage_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_req,
    input  logic          eng_push,
    input  logic          eng_pop,
    input  logic [DW-1:0] eng_wdata,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    output stage_op_e     op,
    output logic [DW-1:0] op_data,
    output logic          cpu_stall
);

    logic eng_any;
    logic cpu_any;

    always_comb begin
        eng_any   = eng_push | eng_pop;
        cpu_any   = cpu_wr | cpu_rd;
        op        = OP_NONE;
        op_data   = cpu_wdata;
        cpu_stall = cpu_any & (flush_req | eng_any);
        if (flush_req) begin
            op = OP_FLUSH;
        end else if (eng_push) begin
            op      = OP_PUSH;
            op_data = eng_wdata;
        end else if (eng_pop) begin
            op = OP_POP;
        end else if (cpu_wr) begin
            op = OP_PUSH;
        end else if (cpu_rd) begin
            op = OP_POP;
        end
    end

    // R9: engine strobes block a processor access in the same cycle
    a_r9_engine_first: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_push || eng_pop) && (cpu_wr || cpu_rd) |-> cpu_stall);

    // R10: flush overrides every other request
    a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> op == OP_FLUSH);

endmodule

// File: rtl/xfer_stage_track.sv
module xfer_stage_track
    import xfer_stage_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stage_op_e     op,
    output logic          push_go,
    output logic          pop_go,
    output logic [CW-1:0] cnt_q,
    output logic          full_q,
    output logic          has_q
);

    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          full;
        logic          has;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        push_go = (op == OP_PUSH) && (st_q.cnt != CNT_MAX);
        pop_go  = (op == OP_POP) && (st_q.cnt != '0);
        if (op == OP_FLUSH) begin
            st_d.cnt  = '0;
            st_d.full = 1'b0;
            st_d.has  = 1'b0;
        end else if (push_go) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == '0)             st_d.has  = 1'b1;
            if (st_q.cnt == CNT_MAX - 1'b1) st_d.full = 1'b1;
        end else if (pop_go) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_MAX)  st_d.full = 1'b0;
            if (st_q.cnt == CW'(1))   st_d.has  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q  = st_q.cnt;
    assign full_q = st_q.full;
    assign has_q  = st_q.has;

    // R2: a push into a full buffer leaves the occupancy alone
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && cnt_q == CNT_MAX) |=> $stable(cnt_q));

    // R3: full flag agrees with the occupancy
    a_r3_full_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        full_q == (cnt_q == CNT_MAX));

    // R5: popping an empty buffer changes nothing
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && cnt_q == '0) |=> ($stable(cnt_q) && !has_q));

    // R6: taking the last byte drops the has-data flag
    a_r6_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && cnt_q == CW'(1)) |=> !has_q);

endmodule

// File: rtl/xfer_stage_store.sv
module xfer_stage_store
    import xfer_stage_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_go,
    input  logic          pop_go,
    input  logic [CW-1:0] cnt_q,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head_q
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] ent;
    } store_t;

    store_t st_d, st_q;
    logic [DEPTH-1:0][DW-1:0] ent_nxt;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] above;
        if (i == DEPTH - 1) begin : g_top
            assign above = '0;
        end else begin : g_mid
            assign above = st_q.ent[i+1];
        end
        always_comb begin
            ent_nxt[i] = st_q.ent[i];
            if (flush) begin
                ent_nxt[i] = '0;
            end else if (pop_go) begin
                ent_nxt[i] = above;
            end else if (push_go && cnt_q == CW'(i)) begin
                ent_nxt[i] = wdata;
            end
        end
    end

    always_comb begin
        st_d.ent = ent_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_q = st_q.ent[0];

    // R7: a flush leaves every entry zero
    a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.ent == '0));

endmodule

// File: rtl/xfer_byte_stage.sv
module xfer_byte_stage
    import xfer_stage_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int IW    = $clog2(DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_wr_en,
    input  logic                 cpu_rd_en,
    input  logic [DW-1:0]        cpu_wdata,
    input  logic                 ctl_wr_en,
    input  logic [DW-1:0]        ctl_wdata,
    input  logic                 eng_push,
    input  logic                 eng_pop,
    input  logic [DW-1:0]        eng_wdata,
    output logic [DW-1:0]        head_data,
    output logic                 cpu_stall,
    output logic signed [IW-1:0] fill_idx,
    output logic                 buf_full,
    output logic                 buf_has_data
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          flush_req;
    logic          ctl_unused;
    stage_op_e     op;
    logic [DW-1:0] op_data;
    logic          push_go;
    logic          pop_go;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] head_q;

    assign flush_req  = ctl_wr_en & ctl_wdata[FLUSH_BIT];
    assign ctl_unused = ^ctl_wdata;

    xfer_stage_arb #(.DW(DW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (flush_req),
        .eng_push  (eng_push),
        .eng_pop   (eng_pop),
        .eng_wdata (eng_wdata),
        .cpu_wr    (cpu_wr_en),
        .cpu_rd    (cpu_rd_en),
        .cpu_wdata (cpu_wdata),
        .op        (op),
        .op_data   (op_data),
        .cpu_stall (cpu_stall)
    );

    xfer_stage_track #(.DEPTH(DEPTH), .CW(CW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .push_go (push_go),
        .pop_go  (pop_go),
        .cnt_q   (cnt_q),
        .full_q  (buf_full),
        .has_q   (buf_has_data)
    );

    xfer_stage_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (op == OP_FLUSH),
        .push_go (push_go),
        .pop_go  (pop_go),
        .cnt_q   (cnt_q),
        .wdata   (op_data),
        .head_q  (head_q)
    );

    assign head_data = (cnt_q == '0) ? {DW{1'b1}} : head_q;
    assign fill_idx  = $signed(IW'(cnt_q) - IW'(1));

    // R1: an empty buffer shows all ones at the head
    a_r1_empty_head: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_idx == -1) |-> (head_data == {DW{1'b1}} && !buf_full));

    // R11: the index only moves in the cycle after an op
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |=> $stable(fill_idx));

endmodule

// File: tb/tb_xfer_byte_stage.sv
module tb_xfer_byte_stage;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_wr_en = 1'b0, cpu_rd_en = 1'b0;
    logic [7:0]        cpu_wdata = '0;
    logic              ctl_wr_en = 1'b0;
    logic [7:0]        ctl_wdata = '0;
    logic              eng_push = 1'b0, eng_pop = 1'b0;
    logic [7:0]        eng_wdata = '0;
    logic [7:0]        head_data;
    logic              cpu_stall;
    logic signed [2:0] fill_idx;
    logic              buf_full, buf_has_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xfer_byte_stage dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en), .cpu_wdata(cpu_wdata),
        .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
        .eng_push(eng_push), .eng_pop(eng_pop), .eng_wdata(eng_wdata),
        .head_data(head_data), .cpu_stall(cpu_stall), .fill_idx(fill_idx),
        .buf_full(buf_full), .buf_has_data(buf_has_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input int idx, input bit full, input bit has);
        chk({req, " idx"}, int'(fill_idx), idx);
        chk({req, " full"}, int'(buf_full), int'(full));
        chk({req, " has"}, int'(buf_has_data), int'(has));
    endtask

    task automatic cpu_write(input logic [7:0] b);
        cpu_wr_en = 1'b1; cpu_wdata = b;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic cpu_read(output logic [7:0] b);
        cpu_rd_en = 1'b1;
        #1 b = head_data;
        @(negedge clk);
        cpu_rd_en = 1'b0;
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wr_en = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk_state("R1 reset", -1, 1'b0, 1'b0);
        chk("R1 head", int'(head_data), 8'hFF);
    endtask

    task automatic t_fill_overflow();
        logic [7:0] b;
        cpu_wr_en = 1'b1; cpu_wdata = 8'h11;
        #1 chk("R11 idx before edge", int'(fill_idx), -1);
        @(negedge clk); cpu_wr_en = 1'b0;
        chk_state("R3 first write", 0, 1'b0, 1'b1);
        cpu_write(8'h22); chk_state("R3 second write", 1, 1'b0, 1'b1);
        cpu_write(8'h33); chk_state("R3 third write", 2, 1'b0, 1'b1);
        cpu_write(8'h44); chk_state("R3 fourth write", 3, 1'b1, 1'b1);
        cpu_write(8'h55); chk_state("R2 overflow ignored", 3, 1'b1, 1'b1);
        cpu_read(b); chk("R4 head 0", int'(b), 8'h11);
        chk_state("R6 read at 3", 2, 1'b0, 1'b1);
        cpu_read(b); chk("R4 head 1", int'(b), 8'h22);
        cpu_read(b); chk("R4 head 2", int'(b), 8'h33);
        cpu_read(b); chk("R2 head 3 not overwritten", int'(b), 8'h44);
        chk_state("R6 read at 0", -1, 1'b0, 1'b0);
    endtask

    task automatic t_empty_read();
        logic [7:0] b;
        cpu_read(b);
        chk("R5 empty read", int'(b), 8'hFF);
        chk_state("R5 empty unchanged", -1, 1'b0, 1'b0);
    endtask

    task automatic t_flush();
        logic [7:0] b;
        cpu_write(8'hA5); cpu_write(8'h5A);
        ctl_write(8'hBF);
        chk_state("R7 no bit6", 1, 1'b0, 1'b1);
        chk("R7 no bit6 head", int'(head_data), 8'hA5);
        ctl_write(8'h40);
        chk_state("R7 flush", -1, 1'b0, 1'b0);
        cpu_read(b); chk("R7 after flush", int'(b), 8'hFF);
    endtask

    task automatic t_engine();
        logic [7:0] b;
        eng_push = 1'b1; eng_wdata = 8'hC1; @(negedge clk);
        eng_wdata = 8'hC2; @(negedge clk);
        eng_push = 1'b0;
        chk_state("R8 engine loads", 1, 1'b0, 1'b1);
        eng_pop = 1'b1;
        #1 chk("R8 engine head", int'(head_data), 8'hC1);
        @(negedge clk); eng_pop = 1'b0;
        cpu_read(b); chk("R8 cpu after engine", int'(b), 8'hC2);
        eng_push = 1'b1; eng_pop = 1'b1; eng_wdata = 8'hC3; @(negedge clk);
        eng_push = 1'b0; eng_pop = 1'b0;
        chk_state("R8 push over pop", 0, 1'b0, 1'b1);
        chk("R8 push over pop head", int'(head_data), 8'hC3);
        ctl_write(8'h40);
    endtask

    task automatic t_stall();
        eng_push = 1'b1; eng_wdata = 8'hE1;
        cpu_wr_en = 1'b1; cpu_wdata = 8'hE2;
        #1 chk("R9 stall", int'(cpu_stall), 1);
        @(negedge clk);
        eng_push = 1'b0;
        #1 chk("R9 retry free", int'(cpu_stall), 0);
        @(negedge clk); cpu_wr_en = 1'b0;
        chk_state("R9 engine first", 1, 1'b0, 1'b1);
        chk("R9 engine byte at head", int'(head_data), 8'hE1);
        cpu_wr_en = 1'b1; cpu_rd_en = 1'b1; cpu_wdata = 8'hE3; @(negedge clk);
        cpu_wr_en = 1'b0; cpu_rd_en = 1'b0;
        chk_state("R9 write over read", 2, 1'b0, 1'b1);
        ctl_wr_en = 1'b1; ctl_wdata = 8'h40; eng_push = 1'b1; cpu_rd_en = 1'b1;
        #1 chk("R10 stall on flush", int'(cpu_stall), 1);
        @(negedge clk);
        ctl_wr_en = 1'b0; eng_push = 1'b0; cpu_rd_en = 1'b0;
        chk_state("R10 flush wins", -1, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_overflow();
        t_empty_read();
        t_flush();
        t_engine();
        t_stall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule